// File: doc/BRIEF.md
# Serial Register Access Port

This block is the slave end of a serial control link. An external host uses it to read and write a bank of 16-bit configuration registers. The core sees those registers on a flat parallel output. The host supplies a serial clock, an active-low frame select and a data line. A second data-out line is used only when the block is set for four-wire wiring. The block runs on the chip's system clock. It oversamples the three host lines through two-stage synchronizers and reacts to the edges it detects on the serial clock. The host's serial clock must therefore be several system clocks per half period.

Each frame holds 24 bits, sent most significant bit first. The first eight bits form an instruction: a direction flag, then a seven-bit register address. Sixteen data bits follow. Bit 0 of register 0 selects the wiring. In three-wire wiring the shared data line turns around and carries read data back. In four-wire wiring read data leaves on the separate output. The bidirectional pin is split into input, output and enable at this boundary, and the pad ring performs the tristate. An enable held low means high impedance.

Top module: `serial_reg_port`

## Requirements
- R1: Bits are sampled on rising edges of the serial clock while the frame select is low. The first bit is the direction flag (1 = read, 0 = write). The next seven bits are the register address, most significant bit first. Sixteen data bits follow, also most significant bit first.
- R2: A write frame updates the addressed register with the full 16-bit word, and does so only after the 16th data bit has been sampled. Registers change at no other time.
- R3: If the frame select rises before the 24th bit, nothing is written. The next frame is decoded from a fresh instruction.
- R4: A read returns the addressed register's contents, most significant bit first. Each bit changes after a falling serial clock edge. The first bit appears after the falling edge that follows the 8th instruction bit.
- R5: With register 0 bit 0 clear (three-wire), read data leaves on `sdio_o` with `sdio_oe` high, and `sdo_oe` stays low for the whole frame.
- R6: With register 0 bit 0 set (four-wire), `sdio_oe` is never asserted and read data leaves on `sdo_o` with `sdo_oe` high.
- R7: After the last falling edge of a read, the active output is driven low. It stays driven until the frame select rises, and its enable drops within a few system clocks after that.
- R8: Only addresses 0 to 63 hold registers. A write to 64 to 127 changes nothing, and a read from them returns zero.
- R9: After reset, register 1 holds 0xA5C3, all other registers hold zero, and both output enables are low.
- R10: Neither output enable is asserted while the frame select is high, nor at any time during a write frame.
- R11: Register i appears on `regs_o[i*16 +: 16]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| sen_n | input | 1 | Active-low frame select from the host |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output value |
| sdio_oe | output | 1 | Shared data line, drive enable |
| sdo_o | output | 1 | Separate read-data output value |
| sdo_oe | output | 1 | Separate read-data output drive enable |
| regs_o | output | 2048 | Register bank toward the core, 16 bits per entry |

## Verification
The properties assume the host changes the frame select and serial clock only far enough apart that the synchronized copies order them the same way. They also assume the mode register is not rewritten while a read is driving. The host model in the bench holds each serial clock phase for eight system clocks. It places data bits on the falling phase, waits a full half period before and after toggling the frame select, and changes the wiring mode only in write frames. Under those conditions the drive enables change only at the synchronized frame and clock edges, and that is what the properties observe.

// File: rtl/srp_pkg.sv
// Shared constants for the serial register port.
// Assumes an 8-bit instruction made of one direction flag and a 7-bit address.
package srp_pkg;
    localparam int INSTR_BITS = 8;
    localparam int ADDR_BITS  = INSTR_BITS - 1;
endpackage

// File: rtl/srp_sync.sv
// Two-stage synchronizer for a bundle of asynchronous host lines.
// Assumes each line is independently slow relative to clk.
module srp_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two flops in series per line, loaded with the idle level in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/srp_frame.sv
// Frame decoder: counts serial clock edges, captures the instruction, issues the
// write strobe after the last data bit and shifts read data out on falling edges.
// Assumes synchronized inputs; a high frame select clears all frame state.
module srp_frame
    import srp_pkg::*;
#(
    parameter int AW = ADDR_BITS,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sen_s,
    input  logic          sdi_s,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          out_bit,
    output logic          out_en
);
    localparam int FRAME = INSTR_BITS + DW;
    localparam int CW    = $clog2(FRAME + 1);

    logic          sclk_d;
    logic          rise, fall;
    logic [CW-1:0] cnt;
    logic [DW-1:0] in_sr;
    logic [DW-1:0] out_sr;
    logic          is_read;

    // Delay the synchronized serial clock for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_d <= 1'b0;
        else        sclk_d <= sclk_s;
    end

    assign rise    = sclk_s & ~sclk_d;
    assign fall    = ~sclk_s & sclk_d;
    assign rd_addr = {in_sr[AW-2:0], sdi_s};

    // Shift, count, capture the instruction and drive read data within one frame.
    always_ff @(posedge clk) begin
        if (!rst_n || sen_s) begin
            cnt     <= '0;
            in_sr   <= '0;
            out_sr  <= '0;
            is_read <= 1'b0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
            out_bit <= 1'b0;
            out_en  <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            if (rise && cnt < CW'(FRAME)) begin
                in_sr <= {in_sr[DW-2:0], sdi_s};
                cnt   <= cnt + 1'b1;
                if (cnt == CW'(INSTR_BITS - 1)) begin
                    is_read <= in_sr[AW-1];
                    wr_addr <= rd_addr;
                    out_sr  <= rd_data;
                end
                if (cnt == CW'(FRAME - 1) && !is_read) begin
                    wr_en   <= 1'b1;
                    wr_data <= {in_sr[DW-2:0], sdi_s};
                end
            end
            if (fall && is_read && cnt >= CW'(INSTR_BITS)) begin
                out_bit <= out_sr[DW-1];
                out_sr  <= {out_sr[DW-2:0], 1'b0};
                out_en  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/srp_regfile.sv
// Register bank: one 16-bit entry per address, present only where the mask is set.
// Absent entries read as zero and ignore writes. Assumes one write per strobe.
module srp_regfile #(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter logic [(2**AW)*DW-1:0] DEFAULTS = '0,
    parameter logic [(2**AW)-1:0]    IMPL     = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data,
    input  logic [AW-1:0]          rd_addr,
    output logic [DW-1:0]          rd_data,
    output logic [(2**AW)*DW-1:0]  regs_o
);
    localparam int N = 2**AW;

    logic [DW-1:0] mem [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        if (IMPL[i]) begin : g_reg
            // Hold one register: default on reset, new word on a matching write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    mem[i] <= DEFAULTS[i*DW +: DW];
                else if (wr_en && wr_addr == AW'(i))
                    mem[i] <= wr_data;
            end
        end else begin : g_hole
            assign mem[i] = '0;
        end
        assign regs_o[i*DW +: DW] = mem[i];
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/serial_reg_port.sv
// Top of the serial register port: synchronizes host lines, decodes frames and
// routes read data to the shared or separate output by the wiring mode bit.
// Assumes the host holds each serial clock phase for at least four clk cycles.
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int AW        = ADDR_BITS,
    parameter int DW        = 16,
    parameter int MODE_ADDR = 0,
    parameter int MODE_BIT  = 0,
    parameter logic [(2**AW)*DW-1:0] REG_DEFAULTS =
        {{((2**AW)*DW-32){1'b0}}, 32'hA5C3_0000},
    parameter logic [(2**AW)-1:0] IMPL_MASK =
        {{(2**(AW-1)){1'b0}}, {(2**(AW-1)){1'b1}}}
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  sclk,
    input  logic                  sen_n,
    input  logic                  sdio_i,
    output logic                  sdio_o,
    output logic                  sdio_oe,
    output logic                  sdo_o,
    output logic                  sdo_oe,
    output logic [(2**AW)*DW-1:0] regs_o
);
    logic          sclk_s, sen_s, sdi_s;
    logic [DW-1:0] rd_data;
    logic [AW-1:0] rd_addr, wr_addr;
    logic [DW-1:0] wr_data;
    logic          wr_en, out_bit, out_en;
    logic          mode_4w;

    srp_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sen_n, sdio_i}),
        .q     ({sclk_s, sen_s, sdi_s})
    );

    srp_frame #(.AW(AW), .DW(DW)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk_s  (sclk_s),
        .sen_s   (sen_s),
        .sdi_s   (sdi_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .out_bit (out_bit),
        .out_en  (out_en)
    );

    srp_regfile #(.AW(AW), .DW(DW), .DEFAULTS(REG_DEFAULTS), .IMPL(IMPL_MASK)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .regs_o  (regs_o)
    );

    assign mode_4w = regs_o[MODE_ADDR*DW + MODE_BIT];
    assign sdio_o  = out_bit;
    assign sdio_oe = out_en & ~mode_4w;
    assign sdo_o   = out_bit;
    assign sdo_oe  = out_en & mode_4w;
endmodule

// File: rtl/srp_chk.sv
// Property checker for the serial register port, bound to the top module.
// Assumes synchronous active-low reset and well-separated host line changes.
module srp_chk #(
    parameter int AW = 7,
    parameter int DW = 16,
    parameter logic [(2**AW)-1:0] IMPL = '1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sen_s,
    input logic                  sdio_oe,
    input logic                  sdo_oe,
    input logic                  wr_en,
    input logic [AW-1:0]         wr_addr,
    input logic [(2**AW)*DW-1:0] regs_o
);
    logic any_oe;
    assign any_oe = sdio_oe | sdo_oe;

    // R10
    idle_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sen_s |=> !any_oe);

    // R7
    drive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (any_oe && !sen_s) |=> any_oe);

    // R4
    drive_start_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_oe) |-> !$past(sen_s));

    // R2
    no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(regs_o));

    // R8
    hole_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !IMPL[wr_addr]) |=> $stable(regs_o));
endmodule

bind serial_reg_port srp_chk #(.AW(AW), .DW(DW), .IMPL(IMPL_MASK)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sen_s   (sen_s),
    .sdio_oe (sdio_oe),
    .sdo_oe  (sdo_oe),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .regs_o  (regs_o)
);

// File: tb/serial_reg_port_bench.sv
module serial_reg_port_bench;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b0;
    logic sen_n = 1'b1;
    logic host_oe = 1'b0;
    logic host_bit = 1'b0;
    logic sdio_o, sdio_oe, sdo_o, sdo_oe;
    logic [2047:0] regs_o;
    logic line;

    int checks = 0;
    int fails  = 0;
    int idle_cnt = 0;
    logic [15:0] mregs [128];

    always #5 clk = ~clk;

    // Resolved shared line as seen by both ends; weak pull-down when nobody drives.
    assign line = sdio_oe ? sdio_o : (host_oe ? host_bit : 1'b0);

    serial_reg_port u_serial_reg_port (
        .clk     (clk),
        .rst_n   (rst_n),
        .sclk    (sclk),
        .sen_n   (sen_n),
        .sdio_i  (line),
        .sdio_o  (sdio_o),
        .sdio_oe (sdio_oe),
        .sdo_o   (sdo_o),
        .sdo_oe  (sdo_oe),
        .regs_o  (regs_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic bit mode4();
        return mregs[0][0];
    endfunction

    task automatic check_bank(input string req);
        int bad = -1;
        for (int i = 0; i < 128; i++)
            if (regs_o[i*16 +: 16] !== mregs[i] && bad < 0) bad = i;
        if (bad < 0) check(1'b1, req, "bank", 0, 0);
        else check(1'b0, req, $sformatf("bank entry %0d", bad),
                   {16'h0, regs_o[bad*16 +: 16]}, {16'h0, mregs[bad]});
    endtask

    // One host frame; nbits below 24 aborts it early.
    task automatic frame(input bit rd, input int addr, input logic [15:0] wd,
                         input int nbits, input string req);
        logic [23:0] word;
        logic [15:0] got, exp;
        bit pins_ok;
        bit m4;
        word = {rd, 7'(addr), wd};
        got = '0;
        pins_ok = 1'b1;
        m4 = mode4();
        exp = (addr < 64) ? mregs[addr] : 16'h0;
        sen_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            if (i < 8 || !rd || m4) begin
                host_oe  = 1'b1;
                host_bit = (i < 8 || !rd) ? word[23-i] : 1'b0;
            end else begin
                host_oe = 1'b0;
            end
            repeat (HALF) @(negedge clk);
            if (rd && i >= 8) begin
                if (m4) begin
                    got[23-i] = sdo_o;
                    if (!sdo_oe || sdio_oe) pins_ok = 1'b0;
                end else begin
                    got[23-i] = line;
                    if (!sdio_oe || sdo_oe) pins_ok = 1'b0;
                end
            end
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
        if (nbits == 24) begin
            repeat (HALF) @(negedge clk);
            if (rd) begin
                check(got == exp, addr >= 64 ? "R8" : "R4", "read data", {16'h0, got}, {16'h0, exp});
                check(pins_ok, m4 ? "R6" : "R5", "output pin selection", {31'h0, pins_ok}, 1);
                check((m4 ? (sdo_oe && !sdo_o) : (sdio_oe && !sdio_o)), "R7",
                      "driven low after last edge", {30'h0, sdio_oe, sdo_oe}, 0);
                repeat (2*HALF) @(negedge clk);
                check((m4 ? (sdo_oe && !sdo_o) : (sdio_oe && !sdio_o)), "R7",
                      "still low before frame end", {30'h0, sdio_oe, sdo_oe}, 0);
            end
        end
        host_oe = 1'b0;
        sen_n = 1'b1;
        repeat (6) @(negedge clk);
        check(!sdio_oe && !sdo_oe, "R7", "released after frame end",
              {30'h0, sdio_oe, sdo_oe}, 0);
        if (!rd && nbits == 24 && addr < 64) mregs[addr] = wd;
        check_bank(rd ? "R2" : (nbits == 24 ? "R2" : "R3"));
        repeat (HALF) @(negedge clk);
    endtask

    // Per-clock monitor of drive rules against the bench's own view of mode and idle time.
    always @(negedge clk) begin
        if (rst_n) begin
            idle_cnt = sen_n ? idle_cnt + 1 : 0;
            checks++;
            if (idle_cnt >= 4 && (sdio_oe || sdo_oe)) begin
                fails++;
                $display("FAIL R10 drive while idle actual=%b%b expected=00", sdio_oe, sdo_oe);
            end
            if (host_oe && sdio_oe) begin
                fails++;
                $display("FAIL R5 line contention actual=1 expected=0");
            end
            if (mode4() && sdio_oe) begin
                fails++;
                $display("FAIL R6 shared line driven in four-wire actual=1 expected=0");
            end
            if (!mode4() && sdo_oe) begin
                fails++;
                $display("FAIL R5 separate output driven in three-wire actual=1 expected=0");
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 128; i++) mregs[i] = 16'h0;
        mregs[1] = 16'hA5C3;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R9 and R11: reset contents and layout
        check(regs_o[16 +: 16] == 16'hA5C3, "R11", "entry 1 slice", {16'h0, regs_o[16 +: 16]}, 32'hA5C3);
        check(!sdio_oe && !sdo_oe, "R9", "enables after reset", {30'h0, sdio_oe, sdo_oe}, 0);
        check_bank("R9");

        // R4 R5 R7: three-wire read of a default
        frame(1'b1, 1, 16'h0, 24, "R4");
        // R1 R2: writes then readback
        frame(1'b0, 5, 16'h8001, 24, "R1");
        frame(1'b0, 63, 16'h7E5A, 24, "R2");
        frame(1'b1, 5, 16'h0, 24, "R1");
        frame(1'b1, 63, 16'h0, 24, "R2");
        // R8: absent address
        frame(1'b0, 100, 16'hFFFF, 24, "R8");
        frame(1'b1, 100, 16'h0, 24, "R8");
        // R3: aborted write, then a fresh frame
        frame(1'b0, 5, 16'h1234, 20, "R3");
        frame(1'b1, 5, 16'h0, 24, "R3");
        frame(1'b1, 0, 16'h0, 10, "R3");
        frame(1'b1, 63, 16'h0, 24, "R3");
        // R6: switch to four-wire and read there
        frame(1'b0, 0, 16'h0001, 24, "R6");
        frame(1'b1, 63, 16'h0, 24, "R6");
        frame(1'b0, 2, 16'hC3A5, 24, "R6");
        frame(1'b1, 2, 16'h0, 24, "R6");
        frame(1'b1, 0, 16'h0, 24, "R6");
        // R5: back to three-wire
        frame(1'b0, 0, 16'h0000, 24, "R5");
        frame(1'b1, 2, 16'h0, 24, "R5");
        check_bank("R10");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule